// File: doc/BRIEF.md
# Banked Tagged Predictor Index Unit

This unit sits in the fetch front end of a banked, tagged branch-direction predictor. For each access it turns a fetch-block start address, a branch address and externally folded global-history values into the fields the predictor tables need: the bank number, the set index of a tagged table, the partial tag, the set index of the untagged base table, and the slot that the branch occupies inside its 32-byte fetch block. Every field is computed from the unaligned start address, so a prediction and a later update for the same fetch block reach exactly the same entries.

Two copies of the field logic run side by side, one for the prediction request and one for the update request. A small guard state machine remembers which bank the most recent prediction read. An update that lands on that same bank is treated as a port collision and dropped; this modelling is switched by a configuration input that is meant to be tied high. The guard has two states: `ST_IDLE` (no bank latched) and `ST_ARMED` (a bank is latched and valid). Transitions: `PREDICT` (prediction without flush, from either state to `ST_ARMED`, reloading the latched bank), `RELEASE` (update without prediction or flush, `ST_ARMED` to `ST_IDLE`) and `FLUSH` (flush input, any state to `ST_IDLE`). Flush has priority over a prediction in the same cycle, and a prediction over the release. The accept and conflict results are registered and appear one cycle after the update request.

Top module: `bank_pred_index`

## Requirements
- R1: The bank number of either path is bits [2:1] of its start address, i.e. (start >> 1) & 3.
- R2: With bank modelling on, the tagged-table index is ((start >> 3) XOR index_fold) & 255; with it off, it is ((start >> 1) XOR index_fold) & 255.
- R3: The partial tag is ((start >> 1) XOR tag_fold XOR (alt_fold << 1) XOR slot) & 255, where alt_fold is 7 bits wide.
- R4: The base-table index is (start >> 5) & 511.
- R5: The slot is ((branch − (start with bits [4:0] cleared)) >> 1) & 15, and slot_ok is 1 exactly when that unshifted difference is below 32; an update whose branch lies below the aligned start is a usage error.
- R6: A prediction latches its bank; the next update with the same bank, bank modelling on, gives conflict = 1 and accept = 0.
- R7: An update is accepted when no bank is latched, when its bank differs from the latched one, or when bank modelling is off.
- R8: Any update without a same-cycle prediction clears the latched bank, as does a flush, so a following update on that bank is accepted.
- R9: When a prediction and an update arrive together, the update is judged against the previously latched bank and the new prediction's bank becomes the latched one.
- R10: accept and conflict are registered: exactly one of them is 1 in the cycle after an update request, and both are 0 after a cycle without one.
- R11: After reset nothing is latched and accept and conflict are 0.
- R12: A flush in the same cycle as a prediction wins: nothing is latched afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_model_en | input | 1 | Enables bank collision modelling (normally tied high) |
| flush | input | 1 | Discards the latched prediction bank |
| pred_valid | input | 1 | Prediction request |
| pred_start_pc | input | 32 | Fetch-block start address of the prediction |
| pred_branch_pc | input | 32 | Branch address probed by the prediction |
| pred_idx_fold | input | 8 | Folded history for the index |
| pred_tag_fold | input | 8 | Folded history for the tag |
| pred_alt_fold | input | 7 | Second folded history for the tag |
| upd_valid | input | 1 | Update request |
| upd_start_pc | input | 32 | Fetch-block start address of the update |
| upd_branch_pc | input | 32 | Branch address being trained |
| upd_idx_fold | input | 8 | Folded history for the index |
| upd_tag_fold | input | 8 | Folded history for the tag |
| upd_alt_fold | input | 7 | Second folded history for the tag |
| pred_bank | output | 2 | Prediction bank number |
| pred_index | output | 8 | Prediction tagged-table index |
| pred_tag | output | 8 | Prediction partial tag |
| pred_base_idx | output | 9 | Prediction base-table index |
| pred_slot | output | 4 | Prediction branch slot |
| pred_slot_ok | output | 1 | Prediction branch lies inside its block |
| upd_bank | output | 2 | Update bank number |
| upd_index | output | 8 | Update tagged-table index |
| upd_tag | output | 8 | Update partial tag |
| upd_base_idx | output | 9 | Update base-table index |
| upd_slot | output | 4 | Update branch slot |
| upd_slot_ok | output | 1 | Update branch lies inside its block |
| upd_accept | output | 1 | Update was taken, one cycle after the request |
| upd_conflict | output | 1 | Update was dropped for a bank collision, one cycle after the request |

## Verification
The field outputs are combinational, so a wrong shift, mask or history mix is visible in the same cycle the request is driven, and the bench compares every field on every cycle. The only state is the latched bank and its valid bit; a latch that fails to load, clear on release or flush, or that loads from the wrong request shows up one cycle after the next update as an accept where a conflict was due or the reverse. Directed sequences place an update right after a prediction, after a release, after a flush and in the same cycle as a prediction so that each transition of the guard is exposed at the first following update.

// File: rtl/bpi_pkg.sv
package bpi_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } guard_state_e;

endpackage

// File: rtl/bpi_field_calc.sv
module bpi_field_calc #(
    parameter int ADDR_W      = 32,
    parameter int INST_SHIFT  = 1,
    parameter int NUM_BANKS   = 4,
    parameter int BLOCK_BYTES = 32,
    parameter int TABLE_SETS  = 256,
    parameter int BASE_SETS   = 512,
    parameter int TAG_W       = 8,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int IDX_W      = $clog2(TABLE_SETS),
    localparam int BASE_W     = $clog2(BASE_SETS),
    localparam int BLK_W      = $clog2(BLOCK_BYTES),
    localparam int SLOT_W     = BLK_W - INST_SHIFT
) (
    input  logic [ADDR_W-1:0] start_pc,
    input  logic [ADDR_W-1:0] branch_pc,
    input  logic [IDX_W-1:0]  idx_fold,
    input  logic [TAG_W-1:0]  tag_fold,
    input  logic [TAG_W-2:0]  alt_fold,
    input  logic              model_en,
    output logic [BANK_W-1:0] bank,
    output logic [IDX_W-1:0]  index,
    output logic [TAG_W-1:0]  tag,
    output logic [BASE_W-1:0] base_idx,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_ok
);
    // Index starts just above the bank bits when banks are modelled.
    localparam int SHIFT_BANKED = INST_SHIFT + BANK_W;
    localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'(BLOCK_BYTES - 1);
    localparam logic [ADDR_W-1:0] BLK_SPAN = ADDR_W'(BLOCK_BYTES);

    logic [ADDR_W-1:0] inst_addr;
    logic [ADDR_W-1:0] idx_src;
    logic [ADDR_W-1:0] block_base;
    logic [ADDR_W-1:0] byte_offset;
    logic [TAG_W-1:0]  alt_mix;

    always_comb begin
        inst_addr   = start_pc >> INST_SHIFT;
        idx_src     = model_en ? (start_pc >> SHIFT_BANKED) : inst_addr;
        block_base  = start_pc & ~BLK_MASK;
        byte_offset = branch_pc - block_base;
        alt_mix     = {alt_fold, 1'b0};
    end

    always_comb begin
        bank     = inst_addr[BANK_W-1:0];
        index    = idx_src[IDX_W-1:0] ^ idx_fold;
        base_idx = base_field(start_pc);
        slot     = slot_field(byte_offset);
        slot_ok  = (byte_offset < BLK_SPAN);
        tag      = inst_addr[TAG_W-1:0] ^ tag_fold ^ alt_mix ^ TAG_W'(slot);
    end

    function automatic logic [BASE_W-1:0] base_field(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] s;
        s = a >> BLK_W;
        return s[BASE_W-1:0];
    endfunction

    function automatic logic [SLOT_W-1:0] slot_field(input logic [ADDR_W-1:0] d);
        logic [ADDR_W-1:0] s;
        s = d >> INST_SHIFT;
        return s[SLOT_W-1:0];
    endfunction

endmodule

// File: rtl/bpi_bank_guard.sv
module bpi_bank_guard
    import bpi_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              model_en,
    input  logic              flush,
    input  logic              pred_fire,
    input  logic [BANK_W-1:0] pred_bank,
    input  logic              upd_fire,
    input  logic [BANK_W-1:0] upd_bank,
    output logic              upd_accept,
    output logic              upd_conflict
);
    guard_state_e      state_q, state_d;
    logic [BANK_W-1:0] held_bank_q;
    logic              collide;

    // Next-state selection: flush beats predict beats release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!flush && pred_fire) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (flush)          state_d = ST_IDLE;
                else if (pred_fire) state_d = ST_ARMED;
                else if (upd_fire)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            held_bank_q <= '0;
        end else begin
            state_q <= state_d;
            if (!flush && pred_fire) held_bank_q <= pred_bank;
        end
    end

    // Update judged against the bank held before this edge.
    always_comb begin
        collide = upd_fire && model_en && (state_q == ST_ARMED) && (upd_bank == held_bank_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_accept   <= 1'b0;
            upd_conflict <= 1'b0;
        end else begin
            upd_accept   <= upd_fire && !collide;
            upd_conflict <= collide;
        end
    end

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_accept && upd_conflict));
    a_r10_follow: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |=> (upd_accept || upd_conflict));
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fire |=> !(upd_accept || upd_conflict));
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && !pred_fire) |=> (state_q == ST_IDLE));
    a_r12_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == ST_IDLE));
    a_r6_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_fire && !flush) |=> (state_q == ST_ARMED && held_bank_q == $past(pred_bank)));
    a_r7_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && !model_en) |=> upd_accept);
    a_r6_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && state_q == ST_IDLE) |=> !upd_conflict);

endmodule

// File: rtl/bank_pred_index.sv
module bank_pred_index #(
    parameter int ADDR_W      = 32,
    parameter int INST_SHIFT  = 1,
    parameter int NUM_BANKS   = 4,
    parameter int BLOCK_BYTES = 32,
    parameter int TABLE_SETS  = 256,
    parameter int BASE_SETS   = 512,
    parameter int TAG_W       = 8,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int IDX_W      = $clog2(TABLE_SETS),
    localparam int BASE_W     = $clog2(BASE_SETS),
    localparam int SLOT_W     = $clog2(BLOCK_BYTES) - INST_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_model_en,
    input  logic              flush,
    input  logic              pred_valid,
    input  logic [ADDR_W-1:0] pred_start_pc,
    input  logic [ADDR_W-1:0] pred_branch_pc,
    input  logic [IDX_W-1:0]  pred_idx_fold,
    input  logic [TAG_W-1:0]  pred_tag_fold,
    input  logic [TAG_W-2:0]  pred_alt_fold,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_start_pc,
    input  logic [ADDR_W-1:0] upd_branch_pc,
    input  logic [IDX_W-1:0]  upd_idx_fold,
    input  logic [TAG_W-1:0]  upd_tag_fold,
    input  logic [TAG_W-2:0]  upd_alt_fold,
    output logic [BANK_W-1:0] pred_bank,
    output logic [IDX_W-1:0]  pred_index,
    output logic [TAG_W-1:0]  pred_tag,
    output logic [BASE_W-1:0] pred_base_idx,
    output logic [SLOT_W-1:0] pred_slot,
    output logic              pred_slot_ok,
    output logic [BANK_W-1:0] upd_bank,
    output logic [IDX_W-1:0]  upd_index,
    output logic [TAG_W-1:0]  upd_tag,
    output logic [BASE_W-1:0] upd_base_idx,
    output logic [SLOT_W-1:0] upd_slot,
    output logic              upd_slot_ok,
    output logic              upd_accept,
    output logic              upd_conflict
);
    bpi_field_calc #(
        .ADDR_W(ADDR_W), .INST_SHIFT(INST_SHIFT), .NUM_BANKS(NUM_BANKS),
        .BLOCK_BYTES(BLOCK_BYTES), .TABLE_SETS(TABLE_SETS),
        .BASE_SETS(BASE_SETS), .TAG_W(TAG_W)
    ) i_pred_fields (
        .start_pc (pred_start_pc),
        .branch_pc(pred_branch_pc),
        .idx_fold (pred_idx_fold),
        .tag_fold (pred_tag_fold),
        .alt_fold (pred_alt_fold),
        .model_en (bank_model_en),
        .bank     (pred_bank),
        .index    (pred_index),
        .tag      (pred_tag),
        .base_idx (pred_base_idx),
        .slot     (pred_slot),
        .slot_ok  (pred_slot_ok)
    );

    bpi_field_calc #(
        .ADDR_W(ADDR_W), .INST_SHIFT(INST_SHIFT), .NUM_BANKS(NUM_BANKS),
        .BLOCK_BYTES(BLOCK_BYTES), .TABLE_SETS(TABLE_SETS),
        .BASE_SETS(BASE_SETS), .TAG_W(TAG_W)
    ) i_upd_fields (
        .start_pc (upd_start_pc),
        .branch_pc(upd_branch_pc),
        .idx_fold (upd_idx_fold),
        .tag_fold (upd_tag_fold),
        .alt_fold (upd_alt_fold),
        .model_en (bank_model_en),
        .bank     (upd_bank),
        .index    (upd_index),
        .tag      (upd_tag),
        .base_idx (upd_base_idx),
        .slot     (upd_slot),
        .slot_ok  (upd_slot_ok)
    );

    bpi_bank_guard #(
        .BANK_W(BANK_W)
    ) i_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .model_en    (bank_model_en),
        .flush       (flush),
        .pred_fire   (pred_valid),
        .pred_bank   (pred_bank),
        .upd_fire    (upd_valid),
        .upd_bank    (upd_bank),
        .upd_accept  (upd_accept),
        .upd_conflict(upd_conflict)
    );

    // R5 usage rule: a trained branch never sits below its aligned block start.
    logic [ADDR_W-1:0] upd_floor;
    always_comb upd_floor = {upd_start_pc[ADDR_W-1:$clog2(BLOCK_BYTES)], {$clog2(BLOCK_BYTES){1'b0}}};

    a_r5_branch_order: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_branch_pc >= upd_floor));

endmodule

// File: tb/test_bank_pred_index.sv
module test_bank_pred_index;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bank_model_en;
    logic        flush;
    logic        pred_valid;
    logic [31:0] pred_start_pc, pred_branch_pc;
    logic [7:0]  pred_idx_fold, pred_tag_fold;
    logic [6:0]  pred_alt_fold;
    logic        upd_valid;
    logic [31:0] upd_start_pc, upd_branch_pc;
    logic [7:0]  upd_idx_fold, upd_tag_fold;
    logic [6:0]  upd_alt_fold;
    logic [1:0]  pred_bank, upd_bank;
    logic [7:0]  pred_index, pred_tag, upd_index, upd_tag;
    logic [8:0]  pred_base_idx, upd_base_idx;
    logic [3:0]  pred_slot, upd_slot;
    logic        pred_slot_ok, upd_slot_ok;
    logic        upd_accept, upd_conflict;

    int n_tests = 0;
    int n_fail  = 0;
    bit ref_armed = 0;
    bit [1:0] ref_bank = 0;

    always #2 clk = ~clk;

    bank_pred_index i_bank_pred_index (
        .clk(clk), .rst_n(rst_n), .bank_model_en(bank_model_en), .flush(flush),
        .pred_valid(pred_valid), .pred_start_pc(pred_start_pc), .pred_branch_pc(pred_branch_pc),
        .pred_idx_fold(pred_idx_fold), .pred_tag_fold(pred_tag_fold), .pred_alt_fold(pred_alt_fold),
        .upd_valid(upd_valid), .upd_start_pc(upd_start_pc), .upd_branch_pc(upd_branch_pc),
        .upd_idx_fold(upd_idx_fold), .upd_tag_fold(upd_tag_fold), .upd_alt_fold(upd_alt_fold),
        .pred_bank(pred_bank), .pred_index(pred_index), .pred_tag(pred_tag),
        .pred_base_idx(pred_base_idx), .pred_slot(pred_slot), .pred_slot_ok(pred_slot_ok),
        .upd_bank(upd_bank), .upd_index(upd_index), .upd_tag(upd_tag),
        .upd_base_idx(upd_base_idx), .upd_slot(upd_slot), .upd_slot_ok(upd_slot_ok),
        .upd_accept(upd_accept), .upd_conflict(upd_conflict)
    );

    function automatic int e_bank(logic [31:0] s);
        return int'((s >> 1) & 32'd3);
    endfunction
    function automatic int e_index(logic [31:0] s, logic [7:0] f, bit en);
        logic [31:0] a = en ? (s >> 3) : (s >> 1);
        return int'((a ^ {24'd0, f}) & 32'd255);
    endfunction
    function automatic logic [31:0] e_diff(logic [31:0] s, logic [31:0] b);
        return b - (s & ~32'd31);
    endfunction
    function automatic int e_slot(logic [31:0] s, logic [31:0] b);
        return int'((e_diff(s, b) >> 1) & 32'd15);
    endfunction
    function automatic int e_ok(logic [31:0] s, logic [31:0] b);
        return (e_diff(s, b) < 32'd32) ? 1 : 0;
    endfunction
    function automatic int e_tag(logic [31:0] s, logic [31:0] b, logic [7:0] tf, logic [6:0] af);
        logic [31:0] v = (s >> 1) ^ {24'd0, tf} ^ {24'd0, af, 1'b0} ^ 32'(e_slot(s, b));
        return int'(v & 32'd255);
    endfunction
    function automatic int e_base(logic [31:0] s);
        return int'((s >> 5) & 32'd511);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_fields();
        check("R1", "pred bank", int'(pred_bank), e_bank(pred_start_pc));
        check("R1", "upd bank",  int'(upd_bank),  e_bank(upd_start_pc));
        check("R2", "pred index", int'(pred_index), e_index(pred_start_pc, pred_idx_fold, bank_model_en));
        check("R2", "upd index",  int'(upd_index),  e_index(upd_start_pc, upd_idx_fold, bank_model_en));
        check("R3", "pred tag", int'(pred_tag), e_tag(pred_start_pc, pred_branch_pc, pred_tag_fold, pred_alt_fold));
        check("R3", "upd tag",  int'(upd_tag),  e_tag(upd_start_pc, upd_branch_pc, upd_tag_fold, upd_alt_fold));
        check("R4", "pred base", int'(pred_base_idx), e_base(pred_start_pc));
        check("R4", "upd base",  int'(upd_base_idx),  e_base(upd_start_pc));
        check("R5", "pred slot", int'(pred_slot), e_slot(pred_start_pc, pred_branch_pc));
        check("R5", "upd slot",  int'(upd_slot),  e_slot(upd_start_pc, upd_branch_pc));
        check("R5", "pred slot_ok", int'(pred_slot_ok), e_ok(pred_start_pc, pred_branch_pc));
        check("R5", "upd slot_ok",  int'(upd_slot_ok),  e_ok(upd_start_pc, upd_branch_pc));
    endtask

    // Inputs are already applied just after a falling edge.
    task automatic run_cycle(string req);
        bit hit;
        #1;
        check_fields();
        hit = upd_valid && bank_model_en && ref_armed && (e_bank(upd_start_pc) == int'(ref_bank));
        @(posedge clk);
        #1;
        check(req, "accept",   int'(upd_accept),   int'(upd_valid && !hit));
        check(req, "conflict", int'(upd_conflict), int'(hit));
        if (flush) ref_armed = 0;
        else if (pred_valid) begin ref_armed = 1; ref_bank = 2'(e_bank(pred_start_pc)); end
        else if (upd_valid) ref_armed = 0;
    endtask

    task automatic idle_inputs();
        flush = 0; pred_valid = 0; upd_valid = 0;
    endtask

    task automatic set_pred(logic [31:0] s, logic [31:0] b);
        pred_valid = 1; pred_start_pc = s; pred_branch_pc = b;
    endtask
    task automatic set_upd(logic [31:0] s, logic [31:0] b);
        upd_valid = 1; upd_start_pc = s; upd_branch_pc = b;
    endtask

    task automatic directed(string req, bit pv, logic [31:0] ps, bit uv, logic [31:0] us, bit fl);
        @(negedge clk);
        idle_inputs();
        if (pv) set_pred(ps, ps);
        if (uv) set_upd(us, us);
        flush = fl;
        run_cycle(req);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; bank_model_en = 1; idle_inputs();
        pred_start_pc = 32'h1000; pred_branch_pc = 32'h1000;
        upd_start_pc = 32'h1000; upd_branch_pc = 32'h1000;
        pred_idx_fold = 8'h3c; pred_tag_fold = 8'ha5; pred_alt_fold = 7'h15;
        upd_idx_fold = 8'h3c; upd_tag_fold = 8'ha5; upd_alt_fold = 7'h15;
        repeat (3) @(posedge clk);
        #1;
        check("R11", "reset accept", int'(upd_accept), 0);
        check("R11", "reset conflict", int'(upd_conflict), 0);
        @(negedge clk);
        rst_n = 1;
        // R11: update straight after reset is accepted (nothing latched)
        directed("R11", 0, 0, 1, 32'h1000, 0);

        // R6: predict bank 0 then update bank 0 -> conflict
        directed("R6", 1, 32'h1000, 0, 0, 0);
        directed("R6", 0, 0, 1, 32'h1000, 0);
        // R8: latch released by previous update, same bank accepted
        directed("R8", 0, 0, 1, 32'h1000, 0);
        // R7: different bank accepted
        directed("R7", 1, 32'h1002, 0, 0, 0);
        directed("R7", 0, 0, 1, 32'h1004, 0);
        // R8: flush clears latch
        directed("R8", 1, 32'h2006, 0, 0, 0);
        directed("R8", 0, 0, 0, 0, 1);
        directed("R8", 0, 0, 1, 32'h2006, 0);
        // R9: simultaneous predict and update
        directed("R9", 1, 32'h3002, 0, 0, 0);
        directed("R9", 1, 32'h3006, 1, 32'h4002, 0);
        directed("R9", 0, 0, 1, 32'h5006, 0);
        // R12: flush beats prediction
        directed("R12", 1, 32'h6004, 0, 0, 1);
        directed("R12", 0, 0, 1, 32'h6004, 0);
        // R7/R2: modelling off
        @(negedge clk); bank_model_en = 0;
        directed("R7", 1, 32'h7000, 0, 0, 0);
        directed("R7", 0, 0, 1, 32'h7000, 0);
        @(negedge clk); bank_model_en = 1;
        // R5: branch beyond the block and at the last slot
        @(negedge clk); idle_inputs();
        set_pred(32'h8012, 32'h8000 + 32'd34);
        set_upd(32'h801e, 32'h801e);
        run_cycle("R5");

        for (int i = 0; i < 600; i++) begin
            logic [31:0] ps, us;
            @(negedge clk);
            idle_inputs();
            ps = $urandom & 32'h0000_0ffe;
            us = ($urandom & 1) ? ps : ($urandom & 32'h0000_0ffe);
            pred_valid = ($urandom % 3) != 0;
            upd_valid  = ($urandom % 2) != 0;
            flush      = ($urandom % 13) == 0;
            bank_model_en = ($urandom % 8) != 0;
            pred_start_pc = ps; pred_branch_pc = (ps & ~32'd31) + (($urandom % 40) & ~32'd1);
            upd_start_pc = us;  upd_branch_pc  = (us & ~32'd31) + (($urandom % 40) & ~32'd1);
            pred_idx_fold = 8'($urandom); pred_tag_fold = 8'($urandom); pred_alt_fold = 7'($urandom);
            upd_idx_fold  = 8'($urandom); upd_tag_fold  = 8'($urandom); upd_alt_fold  = 7'($urandom);
            run_cycle("R10");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule